// File: doc/BRIEF.md
# Function Power-State and Reset-Context Controller

This block keeps the device power state of a single PCI function and decides what each reset is allowed to clear. It follows six states: D0-uninitialized, D0-active, D1, D2, D3hot and D3cold. The state changes in response to the command-register enable bits, to software writes of the power-state field, to the PCI reset and to the global reset. The configuration decoder sits outside the block. It presents each write as a strobe together with the 2-bit power-state field and the PME-enable bit.

The block drives three things. The first is a function-level reset for the ordinary configuration, socket and legacy registers. The second is a permit that gates PME and interrupt signalling. The third is a per-bit clear qualifier for a vector of context registers. The global reset (`rst_ni`, asynchronous) clears everything. Two resets are milder: the PCI reset, and the one-cycle internal reset raised when software leaves D3hot for D0. Neither of them touches the PME-enable bit. While PME is enabled, both also spare the context bits marked sticky by `STICKY_MASK`.

Top module: `pm_state_ctrl`

## Requirements
- R1: While `rst_ni` is low, `pstate_o` is D0-uninitialized, `pme_en_o` is 0 and every bit of `ctx_clr_o` is 1, independent of the clock.
- R2: `permit_o` is 0 whenever the state is D0-uninitialized or D3cold, and 1 in D0-active, D1, D2 and D3hot.
- R3: From D0-uninitialized the state moves to D0-active at the next clock edge only when both `io_en_i` and `mem_en_i` are 1. One enable alone leaves it in D0-uninitialized.
- R4: In D0-active, clearing either enable returns the state to D0-uninitialized at the next edge.
- R5: While `pci_rst_ni` is low, `func_rst_o` is 1 and the state becomes D3cold at the next edge. The first edge with `pci_rst_ni` high moves D3cold to D0-uninitialized. Power-state writes are ignored while the PCI reset is low.
- R6: A PCI reset leaves `pme_en_o` unchanged. While `func_rst_o` is 1 and `rst_ni` is high, `ctx_clr_o` is `~STICKY_MASK` when `pme_en_o` is 1 and all ones when it is 0. When `func_rst_o` is 0, `ctx_clr_o` is all zeros.
- R7: A write of field value D0 while in D3hot moves the state to D0-uninitialized. The same write raises `func_rst_o` for exactly the one clock cycle that follows the write edge.
- R8: A write with `csr_wr_i` high and `pci_rst_ni` high loads `csr_pme_en_i` into `pme_en_o` at that edge, whatever the power-state transition does.
- R9: A write that targets a lighter non-D0 state is ignored and the state stays unchanged. This covers D1 or D2 from D3hot, and D1 from D2.
- R10: Field encoding on `csr_ps_i`: 2'b00 = D0, 2'b01 = D1, 2'b10 = D2, 2'b11 = D3hot. State encoding on `pstate_o`: 0 = D0-uninitialized, 1 = D0-active, 2 = D1, 3 = D2, 4 = D3hot, 5 = D3cold.
- R11: A write of D0 from D1 or D2 enters D0-active if both enables are 1 and D0-uninitialized otherwise. It raises no function reset.
- R12: In D1, D2 and D3hot the enable inputs have no effect on the state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Global reset, asynchronous, active low |
| pci_rst_ni | input | 1 | PCI reset, synchronous, active low |
| io_en_i | input | 1 | Command-register I/O space enable |
| mem_en_i | input | 1 | Command-register memory space enable |
| csr_wr_i | input | 1 | Write strobe for the PM control/status register |
| csr_ps_i | input | 2 | Power-state field of the write |
| csr_pme_en_i | input | 1 | PME-enable bit of the write |
| pstate_o | output | 3 | Current power state (R10 encoding) |
| func_rst_o | output | 1 | Function-level reset for ordinary registers |
| permit_o | output | 1 | PME / interrupt permit |
| pme_en_o | output | 1 | Stored PME-enable bit |
| ctx_clr_o | output | CTX_W | Per-bit clear qualifier for context registers |

## Verification
The assertions check the following on every cycle:
- While PME is enabled, no sticky bit ever receives a clear.
- The function reset caused by a D3hot exit always follows a D3hot cycle and never lasts two cycles.
- A PCI reset never alters the PME-enable bit.
- A PCI reset release always lands in D0-uninitialized.
- D3hot never leads to D1 or D2.

Some properties depend on a specific input history, and only the bench's vector sequence shows them: the exact target chosen for each write from each state, the return to D0 from D1 and D2 depending on the enables, writes ignored during a PCI reset, and the clear pattern with PME on versus off. The asynchronous effect of the global reset in the middle of operation is also covered by a directed test.

// File: rtl/pm_pkg.sv
package pm_pkg;
  typedef enum logic [2:0] {
    PS_D0_UNINIT = 3'd0,
    PS_D0_ACT    = 3'd1,
    PS_D1        = 3'd2,
    PS_D2        = 3'd3,
    PS_D3_HOT    = 3'd4,
    PS_D3_COLD   = 3'd5
  } pm_state_e;

  localparam logic [1:0] FLD_D0 = 2'b00;
  localparam logic [1:0] FLD_D1 = 2'b01;
  localparam logic [1:0] FLD_D2 = 2'b10;
  localparam logic [1:0] FLD_D3 = 2'b11;
endpackage

// File: rtl/pm_fsm.sv
module pm_fsm
  import pm_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      pci_rst_ni,
  input  logic      io_en_i,
  input  logic      mem_en_i,
  input  logic      wr_i,
  input  logic [1:0] ps_i,
  output pm_state_e state_o,
  output logic      d3_exit_o
);
  pm_state_e state_q, state_d;
  logic      exit_d, exit_q;
  logic      both_en;
  pm_state_e d0_tgt;

  assign both_en = io_en_i & mem_en_i;
  assign d0_tgt  = both_en ? PS_D0_ACT : PS_D0_UNINIT;

  always_comb begin
    state_d = state_q;
    exit_d  = 1'b0;
    if (!pci_rst_ni) begin
      state_d = PS_D3_COLD;
    end else begin
      unique case (state_q)
        PS_D3_COLD: state_d = PS_D0_UNINIT;
        PS_D0_UNINIT, PS_D0_ACT: begin
          if (wr_i && ps_i == FLD_D1)      state_d = PS_D1;
          else if (wr_i && ps_i == FLD_D2) state_d = PS_D2;
          else if (wr_i && ps_i == FLD_D3) state_d = PS_D3_HOT;
          else                             state_d = d0_tgt;
        end
        PS_D1: begin
          if (wr_i) begin
            unique case (ps_i)
              FLD_D0:  state_d = d0_tgt;
              FLD_D2:  state_d = PS_D2;
              FLD_D3:  state_d = PS_D3_HOT;
              default: state_d = PS_D1;
            endcase
          end
        end
        PS_D2: begin
          if (wr_i && ps_i == FLD_D0)      state_d = d0_tgt;
          else if (wr_i && ps_i == FLD_D3) state_d = PS_D3_HOT;
        end
        PS_D3_HOT: begin
          // only D0 leaves D3hot; it costs an internal reset
          if (wr_i && ps_i == FLD_D0) begin
            state_d = PS_D0_UNINIT;
            exit_d  = 1'b1;
          end
        end
        default: state_d = PS_D0_UNINIT;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= PS_D0_UNINIT;
      exit_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      exit_q  <= exit_d;
    end
  end

  assign state_o   = state_q;
  assign d3_exit_o = exit_q;
endmodule

// File: rtl/pm_csr.sv
module pm_csr (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pci_rst_ni,
  input  logic wr_i,
  input  logic pme_en_i,
  output logic pme_en_o
);
  logic pme_en_q;

  // global reset only; PCI reset and D3hot exit leave it alone
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  pme_en_q <= 1'b0;
    else if (pci_rst_ni && wr_i)  pme_en_q <= pme_en_i;
  end

  assign pme_en_o = pme_en_q;
endmodule

// File: rtl/pm_ctx_qual.sv
module pm_ctx_qual #(
  parameter int unsigned          CTX_W       = 8,
  parameter logic [CTX_W-1:0]     STICKY_MASK = '1
) (
  input  logic             rst_ni,
  input  logic             func_rst_i,
  input  logic             pme_en_i,
  output logic [CTX_W-1:0] clr_o
);
  for (genvar i = 0; i < CTX_W; i++) begin : g_bit
    if (STICKY_MASK[i]) begin : g_sticky
      assign clr_o[i] = ~rst_ni | (func_rst_i & ~pme_en_i);
    end else begin : g_plain
      assign clr_o[i] = ~rst_ni | func_rst_i;
    end
  end
endmodule

// File: rtl/pm_state_ctrl.sv
module pm_state_ctrl
  import pm_pkg::*;
#(
  parameter int unsigned      CTX_W       = 8,
  parameter logic [CTX_W-1:0] STICKY_MASK = 8'hF0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pci_rst_ni,
  input  logic             io_en_i,
  input  logic             mem_en_i,
  input  logic             csr_wr_i,
  input  logic [1:0]       csr_ps_i,
  input  logic             csr_pme_en_i,
  output logic [2:0]       pstate_o,
  output logic             func_rst_o,
  output logic             permit_o,
  output logic             pme_en_o,
  output logic [CTX_W-1:0] ctx_clr_o
);
  pm_state_e state;
  logic      d3_exit;

  pm_fsm i_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .pci_rst_ni (pci_rst_ni),
    .io_en_i    (io_en_i),
    .mem_en_i   (mem_en_i),
    .wr_i       (csr_wr_i),
    .ps_i       (csr_ps_i),
    .state_o    (state),
    .d3_exit_o  (d3_exit)
  );

  pm_csr i_csr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .pci_rst_ni (pci_rst_ni),
    .wr_i       (csr_wr_i),
    .pme_en_i   (csr_pme_en_i),
    .pme_en_o   (pme_en_o)
  );

  assign func_rst_o = ~pci_rst_ni | d3_exit;
  assign permit_o   = (state != PS_D0_UNINIT) && (state != PS_D3_COLD);
  assign pstate_o   = state;

  pm_ctx_qual #(
    .CTX_W       (CTX_W),
    .STICKY_MASK (STICKY_MASK)
  ) i_ctx (
    .rst_ni     (rst_ni),
    .func_rst_i (func_rst_o),
    .pme_en_i   (pme_en_o),
    .clr_o      (ctx_clr_o)
  );
endmodule

// File: rtl/pm_state_ctrl_chk.sv
module pm_state_ctrl_chk #(
  parameter int unsigned      CTX_W       = 8,
  parameter logic [CTX_W-1:0] STICKY_MASK = 8'hF0
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             pci_rst_ni,
  input logic [2:0]       pstate_o,
  input logic             func_rst_o,
  input logic             permit_o,
  input logic             pme_en_o,
  input logic [CTX_W-1:0] ctx_clr_o
);
  AST_STATE_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pstate_o <= 3'd5); // R10

  AST_UNINIT_NO_PERMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pstate_o == 3'd0) |-> !permit_o); // R2

  AST_RELEASE_TO_UNINIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pci_rst_ni) |=> (pstate_o == 3'd0)); // R5

  AST_PCIRST_KEEPS_PME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pci_rst_ni |=> $stable(pme_en_o)); // R6

  AST_STICKY_SPARED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pme_en_o |-> ((ctx_clr_o & STICKY_MASK) == '0)); // R6

  AST_EXIT_PULSE_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pci_rst_ni && func_rst_o) |=> (!func_rst_o || !pci_rst_ni)); // R7

  AST_EXIT_FROM_D3HOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pci_rst_ni && func_rst_o) |-> ($past(pstate_o) == 3'd4)); // R7

  AST_D3HOT_NO_LIGHT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pstate_o == 3'd4) |=> (pstate_o == 3'd4 || pstate_o == 3'd0 || pstate_o == 3'd5)); // R9
endmodule

bind pm_state_ctrl pm_state_ctrl_chk #(
  .CTX_W       (CTX_W),
  .STICKY_MASK (STICKY_MASK)
) i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .pci_rst_ni (pci_rst_ni),
  .pstate_o   (pstate_o),
  .func_rst_o (func_rst_o),
  .permit_o   (permit_o),
  .pme_en_o   (pme_en_o),
  .ctx_clr_o  (ctx_clr_o)
);

// File: tb/test_pm_state_ctrl.sv
`timescale 1ns/1ps
module test_pm_state_ctrl;
  localparam int unsigned CTX_W = 8;
  localparam logic [CTX_W-1:0] MASK = 8'hF0;
  localparam int NV = 22;

  logic clk = 1'b0;
  logic rst_ni = 1'b0, pci_rst_ni = 1'b1, io_en = 1'b0, mem_en = 1'b0;
  logic csr_wr = 1'b0, csr_pme = 1'b0;
  logic [1:0] csr_ps = 2'b00;
  logic [2:0] pstate;
  logic func_rst, permit, pme_en;
  logic [CTX_W-1:0] ctx_clr;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  pm_state_ctrl #(.CTX_W(CTX_W), .STICKY_MASK(MASK)) i_pm_state_ctrl (
    .clk_i(clk), .rst_ni(rst_ni), .pci_rst_ni(pci_rst_ni),
    .io_en_i(io_en), .mem_en_i(mem_en), .csr_wr_i(csr_wr),
    .csr_ps_i(csr_ps), .csr_pme_en_i(csr_pme),
    .pstate_o(pstate), .func_rst_o(func_rst), .permit_o(permit),
    .pme_en_o(pme_en), .ctx_clr_o(ctx_clr)
  );

  // {pci, io, mem, wr, ps[1:0], pme, st[2:0], frst, perm, pme_o, ctx[7:0]}
  function automatic logic [20:0] v(bit pci, bit io, bit mem, bit wr, int ps, bit pme,
                                    int st, bit frst, bit perm, bit pmeo, int ctx);
    return {pci, io, mem, wr, 2'(ps), pme, 3'(st), frst, perm, pmeo, 8'(ctx)};
  endfunction

  localparam logic [20:0] VEC [NV] = '{
    v(1,1,0,0,0,0, 0,0,0,0,8'h00), // R3 one enable only
    v(1,1,1,0,0,0, 1,0,1,0,8'h00), // R3
    v(1,0,1,0,0,0, 0,0,0,0,8'h00), // R4
    v(1,1,1,0,0,0, 1,0,1,0,8'h00), // R3
    v(1,1,1,1,1,0, 2,0,1,0,8'h00), // R10 D1
    v(1,0,0,0,0,0, 2,0,1,0,8'h00), // R12
    v(1,0,0,1,2,0, 3,0,1,0,8'h00), // R10 D2
    v(1,0,0,1,1,0, 3,0,1,0,8'h00), // R9 D2->D1 ignored
    v(1,0,0,1,0,0, 0,0,0,0,8'h00), // R11
    v(1,1,1,0,0,0, 1,0,1,0,8'h00), // R3
    v(1,1,1,1,3,1, 4,0,1,1,8'h00), // R8 R10 D3hot
    v(1,1,1,1,1,1, 4,0,1,1,8'h00), // R9 D3hot->D1 ignored
    v(1,1,1,1,0,1, 0,1,0,1,8'h0F), // R7 exit pulse, sticky spared
    v(1,1,1,0,0,0, 1,0,1,1,8'h00), // R7 pulse over
    v(0,1,1,0,0,0, 5,1,0,1,8'h0F), // R5 R6
    v(0,1,1,1,0,0, 5,1,0,1,8'h0F), // R5 write ignored, R6
    v(1,0,0,0,0,0, 0,0,0,1,8'h00), // R5 release
    v(1,0,0,1,3,0, 4,0,1,0,8'h00), // R8
    v(1,0,0,1,0,0, 0,1,0,0,8'hFF), // R7 R6 no PME
    v(1,0,0,0,0,0, 0,0,0,0,8'h00), // R7
    v(0,0,0,0,0,0, 5,1,0,0,8'hFF), // R6
    v(1,0,0,0,0,0, 0,0,0,0,8'h00)  // R5
  };

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    #3;
    chk("R1 state", int'(pstate), 0);
    chk("R1 pme_en", int'(pme_en), 0);
    chk("R1 ctx_clr", int'(ctx_clr), 8'hFF);
    chk("R2 permit", int'(permit), 0);
    @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    for (int i = 0; i < NV; i++) begin
      logic [20:0] e;
      e = VEC[i];
      pci_rst_ni = e[20]; io_en = e[19]; mem_en = e[18]; csr_wr = e[17];
      csr_ps = e[16:15]; csr_pme = e[14];
      @(posedge clk);
      @(negedge clk);
      chk($sformatf("R10 vec%0d state", i), int'(pstate), int'(e[13:11]));
      chk($sformatf("R7 vec%0d func_rst", i), int'(func_rst), int'(e[10]));
      chk($sformatf("R2 vec%0d permit", i), int'(permit), int'(e[9]));
      chk($sformatf("R8 vec%0d pme_en", i), int'(pme_en), int'(e[8]));
      chk($sformatf("R6 vec%0d ctx_clr", i), int'(ctx_clr), int'(e[7:0]));
    end
    // directed: global reset mid-run with PME enabled
    io_en = 1'b1; mem_en = 1'b1; csr_wr = 1'b1; csr_ps = 2'b00; csr_pme = 1'b1;
    @(posedge clk); @(negedge clk);
    csr_wr = 1'b0;
    @(posedge clk); @(negedge clk);
    chk("R8 pme set in D0", int'(pme_en), 1);
    chk("R3 D0 active", int'(pstate), 1);
    #1 rst_ni = 1'b0;
    #0.5;
    chk("R1 async state", int'(pstate), 0);
    chk("R1 async pme_en", int'(pme_en), 0);
    chk("R1 async ctx_clr", int'(ctx_clr), 8'hFF);
    @(negedge clk);
    rst_ni = 1'b1;
    @(posedge clk); @(negedge clk);
    chk("R3 after reset", int'(pstate), 1);
    chk("R6 idle ctx", int'(ctx_clr), 0);
    finish_run();
  end

  initial begin
    #(200000 * 4);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end
endmodule